// File: doc/BRIEF.md
# Multi-Output PWM Timer Channel

This block is one 16-bit timer channel that drives up to three pulse-width modulated outputs sharing a single period. The counter counts upward on a count enable taken from a prescaler of the system clock (divide by 1, 2, 4, 8 or 32) or from an external clock pin. That pin passes through a two-flop synchronizer and an edge detector with a selectable active edge. An end-of-period register sets the cycle length. Three duty registers each set the count at which their own output turns active. Each output has its own enable, active polarity and start-up level.

Software starts and stops the channel with a start-bit write. It can read the counter at any time and load it directly. In continuous mode the count wraps forever until a stop write freezes everything in place. In one-shot mode the channel halts by itself at the end of the first period. Compare and overflow events appear as one-cycle pulses. A cutoff input forces every enabled output to its inactive level without disturbing the count.

Top module: `pwm_timer_chan`

## Requirements
- R1: `src_sel_i` picks the count enable: 0, 1, 2, 3 and 4 give one count every 1, 2, 4, 8 and 32 clocks. After a start write the prescaler starts from zero, so the first increment lands K clocks after the running state is entered.
- R2: With `src_sel_i` = 5 the counter advances once per synchronized edge of `ext_clk_i`. `ext_edge_i` selects the edge: 0 rising, 1 falling, 2 both.
- R3: The counter only counts up. On a count enable while it equals `period_i` (m), it returns to 0, so one period lasts m+1 counts.
- R4: An output whose duty value is n sits at its inactive level for n+1 counts and at its active level for m−n counts of each period. `act_lvl_i` bit = 1 means the output is active high. The output turns active on the count enable where the counter equals n, and turns inactive on the one where it equals m; the end-of-period event wins.
- R5: A start write (`start_wr_i`=1, `start_val_i`=1) while stopped loads each output with its `init_lvl_i` bit, which holds until the first compare event.
- R6: A stop write (`start_val_i`=0) clears the running state. Afterwards the counter and all output levels hold.
- R7: With `cont_mode_i`=0 the channel stops by itself on the end-of-period count. The counter is left at 0 and the outputs at their inactive levels.
- R8: `irq_cmp_o` bit 0 (period), bits 1..3 (outputs 0..2) pulse for one clock. The pulse appears in the cycle after the count enable on which the counter equalled that register, together with the updated count.
- R9: `irq_ovf_o` pulses for one clock when the counter steps from all-ones to 0 without an end-of-period match.
- R10: `cnt_wr_i` loads `cnt_wdata_i` into the counter on the next clock, taking priority over counting. `cnt_o` always shows the count.
- R11: While `cutoff_i` is high, every enabled output shows its inactive level, and the counter keeps running.
- R12: An output whose `out_en_i` bit is 0 drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 3 | Count source select |
| ext_clk_i | input | 1 | External count clock pin |
| ext_edge_i | input | 2 | External active edge select |
| start_wr_i | input | 1 | Start-bit write strobe |
| start_val_i | input | 1 | Start-bit value written |
| cont_mode_i | input | 1 | 1 continuous, 0 one-shot |
| period_i | input | 16 | End-of-period compare value m |
| duty_i | input | 48 | Duty values, output j in bits [16j+15:16j] |
| out_en_i | input | 3 | Per-output enable |
| act_lvl_i | input | 3 | Per-output active level |
| init_lvl_i | input | 3 | Per-output level loaded at start |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write value |
| cutoff_i | input | 1 | Forced cutoff |
| cnt_o | output | 16 | Counter value |
| running_o | output | 1 | Channel running |
| pwm_o | output | 3 | PWM outputs |
| irq_cmp_o | output | 4 | Compare event pulses |
| irq_ovf_o | output | 1 | Overflow event pulse |

## Verification
The assertions follow the counter on every cycle. They check the single-step increment, the wrap to zero at the period value, a counter load, the self-halt in one-shot mode, and that the count and output levels freeze while stopped. They also check that the overflow and period pulses coincide with a zero count. The duty-cycle proportions per prescaler setting, the prescaler phase after a start, the edge-selection counts on the external pin, the start-up levels, and the cutoff and enable gating are shown only by the bench's scenarios. These use a sweep of period, duty value and divider with arithmetically predicted pulse widths.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int PRE_W = 5;

    typedef enum logic [2:0] {
        SRC_DIV1  = 3'd0,
        SRC_DIV2  = 3'd1,
        SRC_DIV4  = 3'd2,
        SRC_DIV8  = 3'd3,
        SRC_DIV32 = 3'd4,
        SRC_EXT   = 3'd5
    } cnt_src_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } ext_edge_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [2:0] src_i,
    input  logic [1:0] edge_i,
    input  logic       ext_clk_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [2:0]       sync;
    } tg_state_t;

    tg_state_t        s_d, s_q;
    logic [PRE_W-1:0] mask;
    int unsigned      shift;
    logic             rise, fall, ext_tick;

    always_comb begin
        s_d.presc = run_i ? s_q.presc + 1'b1 : '0;
        s_d.sync  = {s_q.sync[1:0], ext_clk_i};

        rise = s_q.sync[1] & ~s_q.sync[2];
        fall = ~s_q.sync[1] & s_q.sync[2];
        case (ext_edge_e'(edge_i))
            EDGE_RISE: ext_tick = rise;
            EDGE_FALL: ext_tick = fall;
            default:   ext_tick = rise | fall;
        endcase

        case (cnt_src_e'(src_i))
            SRC_DIV2:  shift = 1;
            SRC_DIV4:  shift = 2;
            SRC_DIV8:  shift = 3;
            SRC_DIV32: shift = PRE_W;
            default:   shift = 0;
        endcase
        mask = PRE_W'((32'd1 << shift) - 32'd1);

        if (cnt_src_e'(src_i) == SRC_EXT)
            tick_o = run_i & ext_tick;
        else
            tick_o = run_i & ((s_q.presc & mask) == mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/pwm_out_unit.sv
module pwm_out_unit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic step_i,
    input  logic hit_end_i,
    input  logic hit_duty_i,
    input  logic init_i,
    input  logic act_i,
    input  logic en_i,
    input  logic cutoff_i,
    output logic lvl_o,
    output logic pwm_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (load_i)
            lvl_d = init_i;
        else if (step_i) begin
            if (hit_end_i)       lvl_d = ~act_i;
            else if (hit_duty_i) lvl_d = act_i;
        end

        if (!en_i)         pwm_o = 1'b0;
        else if (cutoff_i) pwm_o = ~act_i;
        else               pwm_o = lvl_q;
        lvl_o = lvl_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= 1'b0;
        else         lvl_q <= lvl_d;
    end

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
    parameter int CNT_W = 16,
    parameter int N_OUT = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2:0]         src_sel_i,
    input  logic               ext_clk_i,
    input  logic [1:0]         ext_edge_i,
    input  logic               start_wr_i,
    input  logic               start_val_i,
    input  logic               cont_mode_i,
    input  logic [CNT_W-1:0]   period_i,
    input  logic [N_OUT*CNT_W-1:0] duty_i,
    input  logic [N_OUT-1:0]   out_en_i,
    input  logic [N_OUT-1:0]   act_lvl_i,
    input  logic [N_OUT-1:0]   init_lvl_i,
    input  logic               cnt_wr_i,
    input  logic [CNT_W-1:0]   cnt_wdata_i,
    input  logic               cutoff_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               running_o,
    output logic [N_OUT-1:0]   pwm_o,
    output logic [N_OUT:0]     irq_cmp_o,
    output logic               irq_ovf_o
);

    localparam int N_CMP = N_OUT + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic [N_CMP-1:0] irq_cmp;
        logic             ovf;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic             tick, step, load_init, hit_end;
    logic [N_OUT-1:0] hit_duty;
    logic [N_OUT-1:0] lvl_q;

    pwm_tick_gen u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (st_q.run),
        .src_i     (src_sel_i),
        .edge_i    (ext_edge_i),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    always_comb begin
        hit_end   = (st_q.cnt == period_i);
        step      = st_q.run & tick & ~cnt_wr_i;
        load_init = start_wr_i & start_val_i & ~st_q.run;
        for (int j = 0; j < N_OUT; j++)
            hit_duty[j] = (st_q.cnt == duty_i[j*CNT_W +: CNT_W]);
    end

    always_comb begin
        st_d         = st_q;
        st_d.irq_cmp = '0;
        st_d.ovf     = 1'b0;

        if (start_wr_i) begin
            if (!start_val_i)     st_d.run = 1'b0;
            else if (!st_q.run)   st_d.run = 1'b1;
        end

        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (step) begin
            st_d.irq_cmp = {hit_duty, hit_end};
            if (hit_end) begin
                st_d.cnt = '0;
                if (!cont_mode_i) st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.ovf = (st_q.cnt == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        pwm_out_unit u_out (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (load_init),
            .step_i     (step),
            .hit_end_i  (hit_end),
            .hit_duty_i (hit_duty[j]),
            .init_i     (init_lvl_i[j]),
            .act_i      (act_lvl_i[j]),
            .en_i       (out_en_i[j]),
            .cutoff_i   (cutoff_i),
            .lvl_o      (lvl_q[j]),
            .pwm_o      (pwm_o[j])
        );
    end

    assign cnt_o     = st_q.cnt;
    assign running_o = st_q.run;
    assign irq_cmp_o = st_q.irq_cmp;
    assign irq_ovf_o = st_q.ovf;

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int CNT_W = 16,
    parameter int N_OUT = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick_i,
    input logic               start_wr_i,
    input logic               cont_mode_i,
    input logic [CNT_W-1:0]   period_i,
    input logic               cnt_wr_i,
    input logic [CNT_W-1:0]   cnt_wdata_i,
    input logic [CNT_W-1:0]   cnt_o,
    input logic               running_o,
    input logic [N_OUT-1:0]   lvl_i,
    input logic [N_OUT:0]     irq_cmp_o,
    input logic               irq_ovf_o
);

    logic step_c;
    assign step_c = running_o & tick_i & ~cnt_wr_i;

    p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_c && cnt_o != period_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

    p_period_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_c && cnt_o == period_i) |=> cnt_o == '0);

    p_cnt_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));

    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && !cnt_wr_i) |=> $stable(cnt_o));

    p_lvl_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && !start_wr_i) |=> $stable(lvl_i));

    p_oneshot_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_c && cnt_o == period_i && !cont_mode_i) |=> !running_o);

    p_ovf_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_ovf_o |-> cnt_o == '0);

    p_end_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_cmp_o[0] |-> cnt_o == '0);

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .start_wr_i  (start_wr_i),
    .cont_mode_i (cont_mode_i),
    .period_i    (period_i),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_wdata_i (cnt_wdata_i),
    .cnt_o       (cnt_o),
    .running_o   (running_o),
    .lvl_i       (lvl_q),
    .irq_cmp_o   (irq_cmp_o),
    .irq_ovf_o   (irq_ovf_o)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int NO = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    src_sel = 3'd0;
    logic          ext_clk = 1'b0;
    logic [1:0]    ext_edge = 2'd0;
    logic          start_wr = 1'b0;
    logic          start_val = 1'b0;
    logic          cont_mode = 1'b1;
    logic [CW-1:0] period = '0;
    logic [NO*CW-1:0] duty = '0;
    logic [NO-1:0] out_en = '0;
    logic [NO-1:0] act_lvl = '0;
    logic [NO-1:0] init_lvl = '0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          cutoff = 1'b0;
    logic [CW-1:0] cnt;
    logic          running;
    logic [NO-1:0] pwm;
    logic [NO:0]   irq_cmp;
    logic          irq_ovf;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer_chan #(.CNT_W(CW), .N_OUT(NO)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .ext_clk_i(ext_clk),
        .ext_edge_i(ext_edge), .start_wr_i(start_wr), .start_val_i(start_val),
        .cont_mode_i(cont_mode), .period_i(period), .duty_i(duty),
        .out_en_i(out_en), .act_lvl_i(act_lvl), .init_lvl_i(init_lvl),
        .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cutoff_i(cutoff),
        .cnt_o(cnt), .running_o(running), .pwm_o(pwm), .irq_cmp_o(irq_cmp),
        .irq_ovf_o(irq_ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_write(input logic v);
        @(negedge clk);
        start_wr = 1'b1; start_val = v;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic cnt_write(input logic [CW-1:0] v);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    function automatic int div_of(input int s);
        return (s == 4) ? 32 : (1 << s);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        // reset state
        check("R3 reset count", int'(cnt), 0);
        check("R6 reset running", int'(running), 0);
        check("R12 reset pwm", int'(pwm), 0);
        check("R8 reset irq", int'({irq_cmp, irq_ovf}), 0);
        rst_n = 1'b1;
        cyc(2);

        // R10: counter write and read
        cnt_write(16'h1234);
        check("R10 counter load", int'(cnt), 'h1234);
        cyc(3);
        check("R10 counter holds while stopped", int'(cnt), 'h1234);

        // R1: prescaler phase after start, divide by 32
        cnt_write(16'd0);
        period = 16'd1000; src_sel = 3'd4; cont_mode = 1'b1;
        start_write(1'b1);
        cyc(31);
        check("R1 no increment before 32 clocks", int'(cnt), 0);
        cyc(1);
        check("R1 increment at 32 clocks", int'(cnt), 1);
        start_write(1'b0);

        // R3 R4 R8 R1: sweep of period, duty and divider
        for (int mi = 0; mi < 3; mi++) begin
            int m;
            m = (mi == 0) ? 3 : (mi == 1) ? 4 : 7;
            for (int n = 0; n <= m; n++) begin
                for (int s = 0; s < 5; s++) begin
                    int k, w;
                    int nd [NO];
                    int act_cnt [NO];
                    int irq_cnt [NO+1];
                    k = div_of(s);
                    nd[0] = n; nd[1] = (n + 1) % (m + 1); nd[2] = 0;
                    start_write(1'b0);
                    cnt_write(16'd0);
                    period = CW'(m);
                    for (int j = 0; j < NO; j++) duty[j*CW +: CW] = CW'(nd[j]);
                    act_lvl = 3'b101; out_en = 3'b111; init_lvl = 3'b000;
                    cont_mode = 1'b1; src_sel = 3'(s);
                    start_write(1'b1);
                    cyc((m + 2) * k + 4);
                    w = 2 * (m + 1) * k;
                    for (int j = 0; j < NO; j++) act_cnt[j] = 0;
                    for (int j = 0; j <= NO; j++) irq_cnt[j] = 0;
                    for (int c = 0; c < w; c++) begin
                        @(negedge clk);
                        for (int j = 0; j < NO; j++)
                            if (pwm[j] == act_lvl[j]) act_cnt[j]++;
                        for (int j = 0; j <= NO; j++)
                            if (irq_cmp[j]) irq_cnt[j]++;
                    end
                    for (int j = 0; j < NO; j++)
                        check($sformatf("R4 active width out%0d m=%0d n=%0d div=%0d", j, m, nd[j], k),
                              act_cnt[j], 2 * (m - nd[j]) * k);
                    for (int j = 0; j <= NO; j++)
                        check($sformatf("R8 compare pulses bit%0d m=%0d div=%0d", j, m, k),
                              irq_cnt[j], 2);
                end
            end
        end

        // R5: initial levels held until first compare
        start_write(1'b0);
        cnt_write(16'd0);
        period = 16'd100; src_sel = 3'd0; cont_mode = 1'b1;
        duty[0 +: CW] = 16'd50; duty[CW +: CW] = 16'd50; duty[2*CW +: CW] = 16'd50;
        act_lvl = 3'b001; init_lvl = 3'b101; out_en = 3'b111;
        start_write(1'b1);
        cyc(10);
        check("R5 initial level out0", int'(pwm[0]), 1);
        check("R5 initial level out1", int'(pwm[1]), 0);
        check("R5 initial level out2", int'(pwm[2]), 1);

        // R11: cutoff forces inactive, counter keeps running
        begin
            int bad;
            logic [CW-1:0] c0;
            bad = 0;
            @(negedge clk);
            cutoff = 1'b1;
            c0 = cnt;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (pwm != (~act_lvl & out_en)) bad++;
            end
            check("R11 cutoff inactive", bad, 0);
            check("R11 counter advances under cutoff", int'(cnt != c0), 1);
            cutoff = 1'b0;
        end

        // R12: disabled outputs drive 0
        begin
            int bad;
            bad = 0;
            out_en = 3'b010; act_lvl = 3'b000;
            for (int c = 0; c < 120; c++) begin
                @(negedge clk);
                if (pwm[0] || pwm[2]) bad++;
            end
            check("R12 disabled outputs low", bad, 0);
            out_en = 3'b111;
        end

        // R6: stop in continuous mode holds counter and levels
        start_write(1'b0);
        cnt_write(16'd0);
        period = 16'd9; duty[0 +: CW] = 16'd4; act_lvl = 3'b111; init_lvl = 3'b000;
        start_write(1'b1);
        cyc(7);
        start_write(1'b0);
        begin
            logic [CW-1:0] c_hold;
            logic [NO-1:0] p_hold;
            c_hold = cnt; p_hold = pwm;
            cyc(20);
            check("R6 running cleared", int'(running), 0);
            check("R6 counter held", int'(cnt), int'(c_hold));
            check("R6 outputs held", int'(pwm), int'(p_hold));
        end

        // R7: one-shot halts at end of period
        cnt_write(16'd0);
        period = 16'd6; duty[0 +: CW] = 16'd2; src_sel = 3'd1;
        act_lvl = 3'b001; init_lvl = 3'b000; cont_mode = 1'b0;
        start_write(1'b1);
        begin
            int hi;
            hi = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (pwm[0]) hi++;
            end
            check("R7 one-shot active width", hi, 8);
        end
        check("R7 one-shot stopped", int'(running), 0);
        check("R7 one-shot count zero", int'(cnt), 0);
        check("R7 one-shot output inactive", int'(pwm[0]), 0);
        cont_mode = 1'b1;

        // R9: overflow pulse
        cnt_write(16'hFFFD);
        period = 16'd5; src_sel = 3'd0;
        start_write(1'b1);
        begin
            int ov;
            ov = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (irq_ovf) ov++;
            end
            check("R9 overflow pulses", ov, 1);
        end
        start_write(1'b0);

        // R2: external clock edges
        for (int e = 0; e < 3; e++) begin
            cnt_write(16'd0);
            period = 16'hFFFF; src_sel = 3'd5; ext_edge = 2'(e);
            start_write(1'b1);
            for (int p = 0; p < 5; p++) begin
                ext_clk = 1'b1; cyc(4);
                ext_clk = 1'b0; cyc(4);
            end
            cyc(6);
            check($sformatf("R2 external edges sel=%0d", e), int'(cnt), (e == 2) ? 10 : 5);
            start_write(1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule